// File: doc/BRIEF.md
# Saturating Motion Accumulator with Status

This block collects signed per-frame X and Y displacement increments into two wide internal accumulators and presents them to a host as a pair of 8-bit two's-complement delta bytes. A delta read hands out at most one byte's worth of movement and subtracts exactly what it reported. A large movement therefore drains over several reads instead of being lost. The block also keeps a status byte with a motion flag and an overflow flag, and it drives an active-low motion-pending pin that a host can poll or use as an interrupt.

A resolution select picks how increments are scaled. At high resolution each increment is added as it arrives. At low resolution each increment is halved by an arithmetic shift, and a one-bit remainder per axis carries the odd count forward so that nothing is dropped. The accumulators are sized for a parameterised number of full-scale reads (32 by default, giving -4096..+4095). On overflow they clamp at their limits instead of wrapping, and the overflow flag records that path data was lost.

All outputs are taken from registered state only. A strobe or increment presented in one cycle is visible on the outputs after the next rising clock edge.

Top module: `mtn_accum`

## Requirements
- R1: After reset, the status byte, both delta bytes and all internal accumulators and remainders are zero, and `motion_n` is high.
- R2: Each delta byte shows its accumulator as an 8-bit two's-complement value (0x80 = -128 through 0x7F = +127). A read strobe subtracts exactly the value shown, so any residual stays for later reads.
- R3: Each accumulator holds signed values from -(DRAIN_READS*128) to DRAIN_READS*128-1 (-4096..4095 by default). An update that would pass a limit clamps at that limit instead of wrapping.
- R4: While an accumulator lies above +127 its delta byte reads 0x7F, and while it lies below -128 its delta byte reads 0x80.
- R5: Status bit 7 (motion) is 1 exactly when at least one accumulator is nonzero, so it stays set until both are fully drained. Status bits 6, 5 and 3..0 are always 0.
- R6: Status bit 4 (overflow) is set in the cycle after any accumulator clamps. It is cleared in the cycle after a delta read whose result leaves neither accumulator at a limit, unless a new clamp occurs in that same cycle.
- R7: A status write clears both accumulators, both remainders, the motion flag and the overflow flag. The written value is not stored, and an increment arriving in the same cycle is discarded.
- R8: `motion_n` is low exactly when status bit 7 is 1.
- R9: With `hi_res` = 1 an increment is added unchanged and the remainders are cleared. With `hi_res` = 0 the value increment+remainder is shifted right arithmetically by one and added, and its low bit becomes the new remainder.
- R10: A delta read and a new increment in the same cycle on the same axis both take effect: the new value is old - reported + increment.
- R11: A status read strobe on its own changes no state and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_valid | input | 1 | Increment strobe for this cycle |
| inc_dx | input | INC_W (8) | Signed X increment |
| inc_dy | input | INC_W (8) | Signed Y increment |
| hi_res | input | 1 | 1 = high resolution, 0 = halved increments |
| rd_status | input | 1 | Status read strobe (no side effect) |
| rd_dy | input | 1 | Y delta read strobe (drains what is shown) |
| rd_dx | input | 1 | X delta read strobe (drains what is shown) |
| wr_status | input | 1 | Status write strobe (clears motion state) |
| status_byte | output | 8 | Bit 7 motion, bit 4 overflow, others 0 |
| dy_byte | output | RPT_W (8) | Saturated Y delta |
| dx_byte | output | RPT_W (8) | Saturated X delta |
| motion_n | output | 1 | Low while motion is pending |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it, because all outputs are decoded from registers without any input path. The bench drives each stimulus on a falling edge. It then advances a reference model just after the following rising edge and queues the expected outputs. A monitor compares them on the next falling edge, so every comparison falls mid-cycle and one cycle after its cause. Overflow and its clearing, and the interaction of a read, a write and an increment in one cycle, are checked at that same one-cycle distance.

// File: rtl/mtn_pkg.sv
package mtn_pkg;
   // status byte field positions
   localparam int unsigned MOT_BIT = 7;
   localparam int unsigned OVF_BIT = 4;
   localparam int unsigned NUM_AXES = 2;
   typedef enum logic [0:0] {AXIS_X = 1'b0, AXIS_Y = 1'b1} axis_e;
endpackage

// File: rtl/mtn_scale.sv
// Resolution scaler: halves increments at low resolution, carrying the odd bit.
module mtn_scale #(
   parameter int unsigned INC_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    inc_valid,
   input  logic [INC_W-1:0]        inc,
   input  logic                    hi_res,
   input  logic                    clr,
   output logic signed [INC_W:0]   add_o
);
   logic signed [INC_W:0] inc_x;
   logic signed [INC_W:0] sum;
   logic signed [INC_W:0] half;
   logic                  rem_q;
   logic                  rem_d;

   always_comb begin
      inc_x = $signed({inc[INC_W-1], inc});
      sum   = inc_x + $signed({{INC_W{1'b0}}, rem_q});
      half  = sum >>> 1;
      if (!inc_valid || clr) add_o = '0;
      else if (hi_res)       add_o = inc_x;
      else                   add_o = half;
   end

   always_comb begin
      if (clr || hi_res)  rem_d = 1'b0;
      else if (inc_valid) rem_d = sum[0];
      else                rem_d = rem_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rem_q <= 1'b0;
      else        rem_q <= rem_d;
   end

   // R9: a cleared scaler never carries a remainder into the next cycle
   assert_rem_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr || hi_res) |=> !rem_q);
endmodule

// File: rtl/mtn_axis.sv
// One axis: wide saturating accumulator drained by clamped byte reads.
module mtn_axis #(
   parameter int unsigned INC_W = 8,
   parameter int unsigned ACC_W = 13,
   parameter int unsigned RPT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_valid,
   input  logic [INC_W-1:0] inc,
   input  logic             hi_res,
   input  logic             rd,
   input  logic             clr,
   output logic [RPT_W-1:0] rpt_o,
   output logic             nonzero_o,
   output logic             hit_o,
   output logic             full_nxt_o
);
   typedef logic signed [ACC_W-1:0] acc_t;
   typedef logic signed [ACC_W+1:0] wide_t;

   localparam wide_t ACC_HI = wide_t'((64'sd1 <<< (ACC_W-1)) - 64'sd1);
   localparam wide_t ACC_LO = wide_t'(-(64'sd1 <<< (ACC_W-1)));
   localparam acc_t  RPT_HI = acc_t'((64'sd1 <<< (RPT_W-1)) - 64'sd1);
   localparam acc_t  RPT_LO = acc_t'(-(64'sd1 <<< (RPT_W-1)));
   localparam logic [RPT_W-1:0] RPT_MAXB = {1'b0, {(RPT_W-1){1'b1}}};
   localparam logic [RPT_W-1:0] RPT_MINB = {1'b1, {(RPT_W-1){1'b0}}};

   acc_t                  acc_q;
   acc_t                  acc_d;
   logic signed [INC_W:0] add;
   wide_t                 raw;
   wide_t                 sub;
   logic                  hit;

   mtn_scale #(.INC_W(INC_W)) scale_i (
      .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc(inc),
      .hi_res(hi_res), .clr(clr), .add_o(add)
   );

   // clamped byte view of the accumulator
   always_comb begin
      if (acc_q > RPT_HI)      rpt_o = RPT_MAXB;
      else if (acc_q < RPT_LO) rpt_o = RPT_MINB;
      else                     rpt_o = acc_q[RPT_W-1:0];
   end

   always_comb begin
      sub = rd ? wide_t'($signed(rpt_o)) : '0;
      raw = wide_t'(acc_q) + wide_t'(add) - sub;
      hit = 1'b0;
      if (clr) begin
         acc_d = '0;
      end else if (raw > ACC_HI) begin
         acc_d = acc_t'(ACC_HI);
         hit   = 1'b1;
      end else if (raw < ACC_LO) begin
         acc_d = acc_t'(ACC_LO);
         hit   = 1'b1;
      end else begin
         acc_d = acc_t'(raw);
      end
   end

   assign hit_o      = hit;
   assign full_nxt_o = (wide_t'(acc_d) == ACC_HI) || (wide_t'(acc_d) == ACC_LO);
   assign nonzero_o  = (acc_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   // R2: a read of an in-range value with nothing added empties the axis
   assert_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !inc_valid && !clr && acc_q <= RPT_HI && acc_q >= RPT_LO) |=> (acc_q == '0));
   // R4: residual beyond byte range reads as full scale
   assert_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q > RPT_HI) |-> (rpt_o == RPT_MAXB));
   // R7: clear empties the axis
   assert_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0));
endmodule

// File: rtl/mtn_flags.sv
// Motion and overflow status plus the motion-pending pin.
module mtn_flags #(
   parameter int unsigned N_AX = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_AX-1:0] nonzero,
   input  logic [N_AX-1:0] hit,
   input  logic [N_AX-1:0] full_nxt,
   input  logic            rd_any,
   input  logic            clr,
   output logic            mot_o,
   output logic            ovf_o,
   output logic            motion_n
);
   logic ovf_q;
   logic ovf_d;

   always_comb begin
      if (clr)                          ovf_d = 1'b0;
      else if (|hit)                    ovf_d = 1'b1;
      else if (rd_any && !(|full_nxt)) ovf_d = 1'b0;
      else                              ovf_d = ovf_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_q <= 1'b0;
      else        ovf_q <= ovf_d;
   end

   assign mot_o    = |nonzero;
   assign ovf_o    = ovf_q;
   assign motion_n = ~mot_o;

   // R6: a clamp is recorded on the next cycle
   assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|hit) && !clr) |=> ovf_q);
   // R7: a status write leaves no motion or overflow pending
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!mot_o && !ovf_q));
endmodule

// File: rtl/mtn_accum.sv
module mtn_accum
   import mtn_pkg::*;
#(
   parameter int unsigned INC_W       = 8,
   parameter int unsigned RPT_W       = 8,
   parameter int unsigned DRAIN_READS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_valid,
   input  logic [INC_W-1:0] inc_dx,
   input  logic [INC_W-1:0] inc_dy,
   input  logic             hi_res,
   input  logic             rd_status,
   input  logic             rd_dy,
   input  logic             rd_dx,
   input  logic             wr_status,
   output logic [7:0]       status_byte,
   output logic [RPT_W-1:0] dy_byte,
   output logic [RPT_W-1:0] dx_byte,
   output logic             motion_n
);
   localparam int unsigned ACC_W = $clog2(DRAIN_READS * (2 ** (RPT_W - 1))) + 1;

   generate
      if (DRAIN_READS < 2) begin : g_bad_drain
         $error("mtn_accum: DRAIN_READS must be at least 2");
      end
      if (INC_W + 1 >= ACC_W) begin : g_bad_inc
         $error("mtn_accum: accumulator must be wider than an increment");
      end
      if (RPT_W < 2 || RPT_W >= ACC_W) begin : g_bad_rpt
         $error("mtn_accum: report width out of range");
      end
   endgenerate

   logic [NUM_AXES-1:0][INC_W-1:0] inc_ax;
   logic [NUM_AXES-1:0][RPT_W-1:0] rpt_ax;
   logic [NUM_AXES-1:0]            rd_ax;
   logic [NUM_AXES-1:0]            nz_ax;
   logic [NUM_AXES-1:0]            hit_ax;
   logic [NUM_AXES-1:0]            full_ax;
   logic                           mot;
   logic                           ovf;

   assign inc_ax[AXIS_X] = inc_dx;
   assign inc_ax[AXIS_Y] = inc_dy;
   assign rd_ax[AXIS_X]  = rd_dx;
   assign rd_ax[AXIS_Y]  = rd_dy;

   generate
      for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
         mtn_axis #(.INC_W(INC_W), .ACC_W(ACC_W), .RPT_W(RPT_W)) axis_i (
            .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc(inc_ax[a]),
            .hi_res(hi_res), .rd(rd_ax[a]), .clr(wr_status),
            .rpt_o(rpt_ax[a]), .nonzero_o(nz_ax[a]), .hit_o(hit_ax[a]),
            .full_nxt_o(full_ax[a])
         );
      end
   endgenerate

   mtn_flags #(.N_AX(NUM_AXES)) flags_i (
      .clk(clk), .rst_n(rst_n), .nonzero(nz_ax), .hit(hit_ax),
      .full_nxt(full_ax), .rd_any(|rd_ax), .clr(wr_status),
      .mot_o(mot), .ovf_o(ovf), .motion_n(motion_n)
   );

   always_comb begin
      status_byte          = '0;
      status_byte[MOT_BIT] = mot;
      status_byte[OVF_BIT] = ovf;
   end

   assign dx_byte = rpt_ax[AXIS_X];
   assign dy_byte = rpt_ax[AXIS_Y];

   // R11: a lone status read leaves every output unchanged
   assert_status_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !inc_valid && !rd_dx && !rd_dy && !wr_status)
      |=> ($stable(status_byte) && $stable(dx_byte) && $stable(dy_byte)));
endmodule

// File: tb/mtn_accum_tb_top.sv
module mtn_accum_tb_top;
   localparam int AMAX = 4095;
   localparam int AMIN = -4096;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       inc_valid = 1'b0;
   logic [7:0] inc_dx = '0;
   logic [7:0] inc_dy = '0;
   logic       hi_res = 1'b1;
   logic       rd_status = 1'b0;
   logic       rd_dy = 1'b0;
   logic       rd_dx = 1'b0;
   logic       wr_status = 1'b0;
   logic [7:0] status_byte;
   logic [7:0] dy_byte;
   logic [7:0] dx_byte;
   logic       motion_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   mtn_accum dut_i (
      .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc_dx(inc_dx),
      .inc_dy(inc_dy), .hi_res(hi_res), .rd_status(rd_status), .rd_dy(rd_dy),
      .rd_dx(rd_dx), .wr_status(wr_status), .status_byte(status_byte),
      .dy_byte(dy_byte), .dx_byte(dx_byte), .motion_n(motion_n)
   );

   // reference model state
   int ax = 0, ay = 0, rx = 0, ry = 0;
   bit ovf = 0;
   logic [24:0] expq[$];
   string       tagq[$];

   function automatic int sat8(int a);
      if (a > 127) return 127;
      if (a < -128) return -128;
      return a;
   endfunction

   function automatic int clampa(int a, ref bit of);
      if (a > AMAX) begin of = 1; return AMAX; end
      if (a < AMIN) begin of = 1; return AMIN; end
      return a;
   endfunction

   function automatic logic [24:0] expected();
      logic [7:0] st;
      bit mot;
      mot = (ax != 0) || (ay != 0);
      st = '0;
      st[7] = mot;
      st[4] = ovf;
      return {st, 8'(sat8(ay)), 8'(sat8(ax)), ~mot};
   endfunction

   task automatic step(input bit v, input int dx, input int dy, input bit hr,
                       input bit rs, input bit rdy, input bit rdx, input bit wr,
                       input string tag);
      int sx, sy, adx, ady, s, nx, ny;
      bit of;
      @(negedge clk);
      inc_valid = v; inc_dx = 8'(dx); inc_dy = 8'(dy); hi_res = hr;
      rd_status = rs; rd_dy = rdy; rd_dx = rdx; wr_status = wr;
      @(posedge clk);
      #2;
      sx = sat8(ax); sy = sat8(ay); adx = 0; ady = 0; of = 0;
      if (wr) begin
         ax = 0; ay = 0; rx = 0; ry = 0; ovf = 0;
      end else begin
         if (v) begin
            if (hr) begin adx = dx; ady = dy; end
            else begin
               s = dx + rx; adx = s >>> 1; rx = s & 1;
               s = dy + ry; ady = s >>> 1; ry = s & 1;
            end
         end
         if (hr) begin rx = 0; ry = 0; end
         nx = clampa(ax + adx - (rdx ? sx : 0), of);
         ny = clampa(ay + ady - (rdy ? sy : 0), of);
         ax = nx; ay = ny;
         if (of) ovf = 1;
         else if ((rdx || rdy) && nx != AMAX && nx != AMIN && ny != AMAX && ny != AMIN)
            ovf = 0;
      end
      expq.push_back(expected());
      tagq.push_back(tag);
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, hi_res, 0, 0, 0, 0, tag);
   endtask

   // monitor: compares one expected item per cycle, mid-cycle
   always @(negedge clk) begin
      if (expq.size() > 0) begin
         logic [24:0] e, g;
         string t;
         e = expq.pop_front();
         t = tagq.pop_front();
         g = {status_byte, dy_byte, dx_byte, motion_n};
         checks++;
         if (g !== e) begin
            errors++;
            $display("FAIL %s: got st=%h dy=%h dx=%h mn=%b exp st=%h dy=%h dx=%h mn=%b",
                     t, g[24:17], g[16:9], g[8:1], g[0], e[24:17], e[16:9], e[8:1], e[0]);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      checks++;
      if ({status_byte, dy_byte, dx_byte, motion_n} !== {8'h00, 8'h00, 8'h00, 1'b1}) begin
         errors++;
         $display("FAIL R1: got st=%h dy=%h dx=%h mn=%b exp 00 00 00 1",
                  status_byte, dy_byte, dx_byte, motion_n);
      end
      rst_n = 1'b1;
      idle("R1 idle after reset");

      // R2 / R5 / R8: small movement, then drain
      step(1, 5, -3, 1, 0, 0, 0, 0, "R2 small inc");
      step(1, 2, -1, 1, 0, 0, 0, 0, "R5 second inc");
      step(0, 0, 0, 1, 1, 0, 0, 0, "R11 status read");
      step(0, 0, 0, 1, 0, 1, 0, 0, "R2 read dy");
      step(0, 0, 0, 1, 0, 0, 1, 0, "R8 read dx pin high");

      // R4 / R2: large positive residual drains in chunks
      for (int i = 0; i < 4; i++) step(1, 100, -100, 1, 0, 0, 0, 0, "R4 accumulate");
      for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 1, 1, 0, "R4 chunk drain");
      idle("R5 empty after drain");

      // R10: read and increment in the same cycle
      step(1, 120, 0, 1, 0, 0, 0, 0, "R10 preload");
      step(1, 30, 7, 1, 0, 0, 1, 0, "R10 read plus inc");
      step(0, 0, 0, 1, 0, 1, 1, 0, "R10 drain");

      // R9: low resolution halving with carried remainder
      step(1, 3, -3, 0, 0, 0, 0, 0, "R9 odd inc");
      step(1, 1, -1, 0, 0, 0, 0, 0, "R9 remainder carry");
      step(1, -128, 127, 0, 0, 0, 0, 0, "R9 extremes");
      step(1, 5, 5, 1, 0, 0, 0, 0, "R9 high res");
      step(0, 0, 0, 1, 0, 1, 1, 0, "R9 drain");

      // R3 / R6: positive overflow clamps, read clears overflow
      for (int i = 0; i < 40; i++) step(1, 127, 0, 1, 0, 0, 0, 0, "R3 clamp positive");
      step(0, 0, 0, 1, 1, 0, 0, 0, "R6 flag held without read");
      step(0, 0, 0, 1, 0, 0, 1, 0, "R6 read clears overflow");
      for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, 1, 0, "R4 drain from clamp");
      step(0, 0, 0, 1, 0, 0, 0, 1, "R7 write clears");

      // R3 / R6: negative overflow; reading the other axis keeps the flag
      for (int i = 0; i < 40; i++) step(1, 0, -128, 1, 0, 0, 0, 0, "R3 clamp negative");
      step(0, 0, 0, 1, 0, 0, 1, 0, "R6 flag stays at limit");
      step(0, 0, 0, 1, 0, 1, 0, 0, "R6 dy read clears");
      step(1, 50, 50, 1, 0, 0, 0, 1, "R7 write beats inc");
      step(1, 3, 0, 0, 0, 0, 0, 0, "R7 remainder start");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R7 clears remainder");
      step(1, 1, 0, 0, 0, 0, 0, 0, "R7 no stale remainder");
      idle("R1 final idle");
      idle("R1 final idle 2");

      @(negedge clk);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule